// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block sequences the power-down state of a small microcontroller core. A one-cycle strobe from the core marks the execution of a sleep instruction. The block then switches the oscillator driver off, clears the power-down flag, sets the timeout flag and pulses a clear to the watchdog counter, which keeps running. While asleep it watches three kinds of wake event: an external reset input, a watchdog timeout (only when the watchdog is enabled) and any interrupt source whose own enable bit is set.

An interrupt or watchdog wake continues the program. The oscillator is switched back on and, for crystal-type oscillator modes, a start-up delay of `OST_CYCLES` clock cycles runs before the core gets a one-cycle resume strobe. In RC mode the delay is skipped. The global interrupt enable plays no part in whether the device wakes; it only decides whether a vector request goes out with the resume strobe. The vector request tells the core to run the already fetched next instruction and then branch to the interrupt vector at 0x0004. An external reset instead forces the block back to the running state with both status flags set. A watchdog timeout while running requests a core reset and clears the timeout flag. The block has no output that drives the external reset pin.

Top module: `slpwk_ctrl`

## Requirements
- R1: After the synchronous `rst`, `pd_flag_o`=1, `to_flag_o`=1, `osc_drv_en_o`=1, and `resume_o`, `vector_req_o`, `wdt_clr_o` and `core_rst_o` are 0.
- R2: A `sleep_exec_i` strobe while running, with no watchdog reset in that cycle, makes the next cycle show `pd_flag_o`=0, `to_flag_o`=1, `osc_drv_en_o`=0 and a one-cycle `wdt_clr_o`. The oscillator stays off for as long as the block sleeps.
- R3: While asleep, interrupt source i wakes the block only when both `irq_flag_i[i]` and `irq_en_i[i]` are 1, whatever the value of `gie_i`. A flag with its enable clear leaves the oscillator off and gives no resume.
- R4: While asleep, a `wdt_timeout_i` pulse wakes the block only when `wdt_en_i`=1. Such a wake clears `to_flag_o` and never requests the vector.
- R5: Every wake from sleep gives a one-cycle `wdt_clr_o` in the cycle after the wake event.
- R6: `osc_mode_i` codes 0, 1 and 2 are crystal modes: `resume_o` rises `OST_CYCLES` cycles after the cycle in which the wake is registered. Code 3 is RC mode: `resume_o` rises in that cycle.
- R7: `resume_o` lasts one cycle. `vector_req_o` is high with it exactly when the wake came from an interrupt and `gie_i` was 1 at the wake event.
- R8: If an enabled interrupt is already pending when sleep is entered, sleep entry still completes as in R2 and the wake follows in the next cycle.
- R9: `ext_rst_i` passes through `SYNC_STAGES` flip-flops. Once it arrives it forces the running state from any state, with `pd_flag_o`=1, `to_flag_o`=1, the oscillator on and `core_rst_o` held high. A start-up delay in progress is abandoned with no resume.
- R10: A `wdt_timeout_i` pulse with `wdt_en_i`=1 while running gives a one-cycle `core_rst_o`, `to_flag_o`=0 and `pd_flag_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sleep_exec_i | input | 1 | One-cycle strobe: sleep instruction executed |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | One-cycle watchdog timeout strobe |
| gie_i | input | 1 | Global interrupt enable |
| irq_flag_i | input | N_IRQ | Interrupt source flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| osc_mode_i | input | 2 | Oscillator mode: 0,1,2 crystal types, 3 RC |
| ext_rst_i | input | 1 | External reset request, asynchronous |
| osc_drv_en_o | output | 1 | Oscillator driver enable |
| wdt_clr_o | output | 1 | One-cycle clear to the watchdog counter |
| pd_flag_o | output | 1 | Power-down status flag |
| to_flag_o | output | 1 | Timeout status flag |
| resume_o | output | 1 | One-cycle strobe: core resumes execution |
| vector_req_o | output | 1 | With resume: branch to the interrupt vector after the next instruction |
| core_rst_o | output | 1 | Core reset request |

## Verification
The assertions check on every cycle the effects of sleep entry and the oscillator being off while asleep. They also check the watchdog clear on each wake, the timeout flag cleared by a watchdog wake, the single-cycle resume with its vector request, the forced state after an external reset and the reset caused by a watchdog timeout while running. Only the bench scenarios can show the exact start-up delay in each oscillator mode, the sources that must not wake the block (disabled enables, a disabled watchdog), the immediate wake on a pending interrupt and the abandoned delay after an external reset. The bench sweeps every oscillator mode, both global enable values and every wake source.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_OST    = 2'd2,
    ST_RESUME = 2'd3
  } slp_state_e;

  localparam logic [1:0] OSC_LP = 2'd0;
  localparam logic [1:0] OSC_XT = 2'd1;
  localparam logic [1:0] OSC_HS = 2'd2;
  localparam logic [1:0] OSC_RC = 2'd3;

endpackage

// File: rtl/slpwk_sync.sv
module slpwk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/slpwk_wake_eval.sv
module slpwk_wake_eval #(
  parameter int unsigned N_IRQ = 3
) (
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             wdt_en_i,
  input  logic             wdt_timeout_i,
  input  logic             gie_i,
  output logic             irq_wake_o,
  output logic             wdt_wake_o,
  output logic             any_wake_o,
  output logic             vec_sel_o
);
  logic [N_IRQ-1:0] hit;

  // Wake qualification ignores the global enable on purpose
  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
      assign hit[g] = irq_flag_i[g] & irq_en_i[g];
    end
  endgenerate

  assign irq_wake_o = |hit;
  assign wdt_wake_o = wdt_en_i & wdt_timeout_i;
  assign any_wake_o = irq_wake_o | wdt_wake_o;
  // Global enable only steers in-line resume versus vectoring
  assign vec_sel_o  = irq_wake_o & gie_i;
endmodule

// File: rtl/slpwk_ost_timer.sv
module slpwk_ost_timer #(
  parameter int unsigned CYCLES = 1024,
  localparam int unsigned W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load_i)             cnt <= W'(CYCLES - 1);
    else if (run_i && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
  import slpwk_pkg::*;
#(
  parameter int unsigned N_IRQ       = 3,
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_exec_i,
  input  logic             wdt_en_i,
  input  logic             wdt_timeout_i,
  input  logic             gie_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [1:0]       osc_mode_i,
  input  logic             ext_rst_i,
  output logic             osc_drv_en_o,
  output logic             wdt_clr_o,
  output logic             pd_flag_o,
  output logic             to_flag_o,
  output logic             resume_o,
  output logic             vector_req_o,
  output logic             core_rst_o
);
  slp_state_e state_q;
  logic ext_q;
  logic irq_wake, wdt_wake, any_wake, vec_sel;
  logic vec_pend_q;
  logic ost_load, ost_run, ost_done;
  logic rc_mode;

  slpwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (ext_rst_i),
    .q_o (ext_q)
  );

  slpwk_wake_eval #(.N_IRQ(N_IRQ)) u_wake (
    .irq_flag_i    (irq_flag_i),
    .irq_en_i      (irq_en_i),
    .wdt_en_i      (wdt_en_i),
    .wdt_timeout_i (wdt_timeout_i),
    .gie_i         (gie_i),
    .irq_wake_o    (irq_wake),
    .wdt_wake_o    (wdt_wake),
    .any_wake_o    (any_wake),
    .vec_sel_o     (vec_sel)
  );

  assign rc_mode  = (osc_mode_i == OSC_RC);
  assign ost_load = !ext_q && (state_q == ST_SLEEP) && any_wake;
  assign ost_run  = (state_q == ST_OST);

  slpwk_ost_timer #(.CYCLES(OST_CYCLES)) u_ost (
    .clk    (clk),
    .rst    (rst),
    .load_i (ost_load),
    .run_i  (ost_run),
    .done_o (ost_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      pd_flag_o    <= 1'b1;
      to_flag_o    <= 1'b1;
      osc_drv_en_o <= 1'b1;
      wdt_clr_o    <= 1'b0;
      resume_o     <= 1'b0;
      vector_req_o <= 1'b0;
      core_rst_o   <= 1'b0;
      vec_pend_q   <= 1'b0;
    end else begin
      wdt_clr_o    <= 1'b0;
      resume_o     <= 1'b0;
      vector_req_o <= 1'b0;
      core_rst_o   <= 1'b0;
      if (ext_q) begin
        // external reset overrides every state
        state_q      <= ST_RUN;
        pd_flag_o    <= 1'b1;
        to_flag_o    <= 1'b1;
        osc_drv_en_o <= 1'b1;
        core_rst_o   <= 1'b1;
        wdt_clr_o    <= 1'b1;
        vec_pend_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RUN: begin
            if (wdt_wake) begin
              core_rst_o <= 1'b1;
              to_flag_o  <= 1'b0;
              pd_flag_o  <= 1'b1;
              wdt_clr_o  <= 1'b1;
            end else if (sleep_exec_i) begin
              state_q      <= ST_SLEEP;
              pd_flag_o    <= 1'b0;
              to_flag_o    <= 1'b1;
              osc_drv_en_o <= 1'b0;
              wdt_clr_o    <= 1'b1;
            end
          end
          ST_SLEEP: begin
            if (any_wake) begin
              wdt_clr_o    <= 1'b1;
              osc_drv_en_o <= 1'b1;
              vec_pend_q   <= vec_sel;
              if (wdt_wake) to_flag_o <= 1'b0;
              if (rc_mode) begin
                state_q      <= ST_RESUME;
                resume_o     <= 1'b1;
                vector_req_o <= vec_sel;
              end else begin
                state_q <= ST_OST;
              end
            end
          end
          ST_OST: begin
            if (ost_done) begin
              state_q      <= ST_RESUME;
              resume_o     <= 1'b1;
              vector_req_o <= vec_pend_q;
            end
          end
          ST_RESUME: begin
            state_q <= ST_RUN;
          end
          default: state_q <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/slpwk_ctrl_chk.sv
module slpwk_ctrl_chk
  import slpwk_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sleep_exec_i,
  input slp_state_e state_q,
  input logic       ext_q,
  input logic       any_wake,
  input logic       wdt_wake,
  input logic       osc_drv_en_o,
  input logic       wdt_clr_o,
  input logic       pd_flag_o,
  input logic       to_flag_o,
  input logic       resume_o,
  input logic       vector_req_o,
  input logic       core_rst_o
);
  // R2: sleep entry updates flags, oscillator and watchdog clear
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && state_q == ST_RUN && sleep_exec_i && !wdt_wake)
      |=> (!pd_flag_o && to_flag_o && !osc_drv_en_o && wdt_clr_o));

  // R2: oscillator off throughout sleep
  a_r2_osc_off: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP) |-> !osc_drv_en_o);

  // R5: any wake clears the watchdog
  a_r5_wake_clr: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && state_q == ST_SLEEP && any_wake) |=> wdt_clr_o);

  // R4: watchdog wake clears the timeout flag
  a_r4_to_clear: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && state_q == ST_SLEEP && wdt_wake) |=> !to_flag_o);

  // R7: vector request only together with resume
  a_r7_vec_pair: assert property (@(posedge clk) disable iff (rst)
    vector_req_o |-> resume_o);

  // R7: resume is a single-cycle strobe
  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    resume_o |=> !resume_o);

  // R9: external reset forces running state with both flags set
  a_r9_ext_reset: assert property (@(posedge clk) disable iff (rst)
    ext_q |=> (state_q == ST_RUN && pd_flag_o && to_flag_o && core_rst_o && osc_drv_en_o));

  // R10: watchdog timeout while running resets the core
  a_r10_wdt_run: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && state_q == ST_RUN && wdt_wake) |=> (core_rst_o && !to_flag_o && pd_flag_o));
endmodule

bind slpwk_ctrl slpwk_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_exec_i (sleep_exec_i),
  .state_q      (state_q),
  .ext_q        (ext_q),
  .any_wake     (any_wake),
  .wdt_wake     (wdt_wake),
  .osc_drv_en_o (osc_drv_en_o),
  .wdt_clr_o    (wdt_clr_o),
  .pd_flag_o    (pd_flag_o),
  .to_flag_o    (to_flag_o),
  .resume_o     (resume_o),
  .vector_req_o (vector_req_o),
  .core_rst_o   (core_rst_o)
);

// File: tb/slpwk_ctrl_bench.sv
`timescale 1ns/1ps
module slpwk_ctrl_bench;
  localparam int N_IRQ = 3;
  localparam int OST   = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_exec_i = 1'b0, wdt_en_i = 1'b0, wdt_timeout_i = 1'b0, gie_i = 1'b0;
  logic [N_IRQ-1:0] irq_flag_i = '0, irq_en_i = '0;
  logic [1:0] osc_mode_i = 2'd0;
  logic ext_rst_i = 1'b0;
  logic osc_drv_en_o, wdt_clr_o, pd_flag_o, to_flag_o, resume_o, vector_req_o, core_rst_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  slpwk_ctrl #(.N_IRQ(N_IRQ), .OST_CYCLES(OST), .SYNC_STAGES(2)) u_slpwk_ctrl (
    .clk(clk), .rst(rst), .sleep_exec_i(sleep_exec_i), .wdt_en_i(wdt_en_i),
    .wdt_timeout_i(wdt_timeout_i), .gie_i(gie_i), .irq_flag_i(irq_flag_i),
    .irq_en_i(irq_en_i), .osc_mode_i(osc_mode_i), .ext_rst_i(ext_rst_i),
    .osc_drv_en_o(osc_drv_en_o), .wdt_clr_o(wdt_clr_o), .pd_flag_o(pd_flag_o),
    .to_flag_o(to_flag_o), .resume_o(resume_o), .vector_req_o(vector_req_o),
    .core_rst_o(core_rst_o)
  );

  task automatic chk(input logic ok, input string msg, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  // Sleep entry; checks the cycle right after the strobe (R2)
  task automatic do_sleep();
    @(negedge clk);
    sleep_exec_i = 1'b1;
    @(negedge clk);
    sleep_exec_i = 1'b0;
    chk(pd_flag_o == 0,    "R2 pd cleared", pd_flag_o, 0);
    chk(to_flag_o == 1,    "R2 to set", to_flag_o, 1);
    chk(osc_drv_en_o == 0, "R2 osc off", osc_drv_en_o, 0);
    chk(wdt_clr_o == 1,    "R2 watchdog clear", wdt_clr_o, 1);
  endtask

  // Count cycles from the wake edge until the resume strobe
  task automatic wait_resume(input int exp_n, input logic exp_vec, input string tag);
    int got = 0;
    logic v = 1'b0;
    for (int n = 1; n <= exp_n + 8; n++) begin
      @(negedge clk);
      if (n == 1) begin
        wdt_timeout_i = 1'b0;
        chk(wdt_clr_o == 1, {"R5 wake watchdog clear ", tag}, wdt_clr_o, 1);
      end
      if (resume_o) begin
        got = n;
        v = vector_req_o;
        break;
      end
    end
    chk(got == exp_n, {"R6 resume delay ", tag}, got, exp_n);
    chk(v == exp_vec, {"R7 vector request ", tag}, v, exp_vec);
    @(negedge clk);
    chk(resume_o == 0, {"R7 single strobe ", tag}, resume_o, 0);
  endtask

  task automatic idle_no_wake(input int cycles, input string tag);
    int seen = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      wdt_timeout_i = 1'b0;
      if (resume_o || osc_drv_en_o) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pd_flag_o == 1 && to_flag_o == 1, "R1 flags after reset", {pd_flag_o, to_flag_o}, 3);
    chk(osc_drv_en_o == 1, "R1 osc on", osc_drv_en_o, 1);
    chk({resume_o, vector_req_o, wdt_clr_o, core_rst_o} == 4'b0, "R1 strobes low",
        {resume_o, vector_req_o, wdt_clr_o, core_rst_o}, 0);

    // Sweep: every oscillator mode, global enable value and wake source (R3 R4 R6 R7)
    wdt_en_i = 1'b1;
    irq_en_i = '1;
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        for (int s = 0; s <= N_IRQ; s++) begin
          osc_mode_i = 2'(m);
          gie_i = g[0];
          do_sleep();
          idle_no_wake(3, "R3 no spurious wake");
          if (s < N_IRQ) irq_flag_i[s] = 1'b1;
          else           wdt_timeout_i = 1'b1;
          wait_resume((m == 3) ? 1 : OST + 1, (s < N_IRQ) && g[0],
                      $sformatf("mode %0d gie %0d src %0d", m, g, s));
          if (s < N_IRQ) chk(to_flag_o == 1, "R4 to kept on interrupt wake", to_flag_o, 1);
          else           chk(to_flag_o == 0, "R4 to cleared on watchdog wake", to_flag_o, 0);
          irq_flag_i = '0;
        end
      end
    end

    // R3: flags with their enables clear do not wake, even with gie set
    osc_mode_i = 2'd1;
    gie_i = 1'b1;
    irq_en_i = 3'b010;
    do_sleep();
    irq_flag_i = 3'b101;
    idle_no_wake(12, "R3 disabled source woke");
    irq_flag_i = 3'b111;
    wait_resume(OST + 1, 1'b1, "R3 enabled source");
    irq_flag_i = '0;

    // R4: watchdog timeout ignored when watchdog disabled
    wdt_en_i = 1'b0;
    gie_i = 1'b0;
    osc_mode_i = 2'd3;
    do_sleep();
    wdt_timeout_i = 1'b1;
    idle_no_wake(8, "R4 disabled watchdog woke");
    irq_flag_i = 3'b010;
    wait_resume(1, 1'b0, "R4 exit by interrupt");
    irq_flag_i = '0;

    // R8: enabled interrupt pending at sleep entry
    osc_mode_i = 2'd2;
    gie_i = 1'b1;
    irq_en_i = 3'b001;
    irq_flag_i = 3'b001;
    do_sleep();
    wait_resume(OST + 1, 1'b1, "R8 immediate wake");
    irq_flag_i = '0;

    // R10: watchdog timeout while running
    wdt_en_i = 1'b1;
    @(negedge clk);
    wdt_timeout_i = 1'b1;
    @(negedge clk);
    wdt_timeout_i = 1'b0;
    chk(core_rst_o == 1, "R10 core reset", core_rst_o, 1);
    chk(to_flag_o == 0,  "R10 to cleared", to_flag_o, 0);
    chk(pd_flag_o == 1,  "R10 pd set", pd_flag_o, 1);
    @(negedge clk);
    chk(core_rst_o == 0, "R10 one cycle", core_rst_o, 0);

    // R9: external reset during the start-up delay
    osc_mode_i = 2'd0;
    do_sleep();
    irq_flag_i = 3'b001;
    repeat (5) @(negedge clk);
    ext_rst_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(core_rst_o == 1, "R9 core reset held", core_rst_o, 1);
    chk(pd_flag_o == 1 && to_flag_o == 1, "R9 flags set", {pd_flag_o, to_flag_o}, 3);
    chk(osc_drv_en_o == 1, "R9 osc on", osc_drv_en_o, 1);
    begin
      int seen = 0;
      for (int n = 0; n < OST + 10; n++) begin
        @(negedge clk);
        if (resume_o) seen++;
        if (!core_rst_o) seen++;
      end
      chk(seen == 0, "R9 delay abandoned", seen, 0);
    end
    ext_rst_i = 1'b0;
    irq_flag_i = '0;
    repeat (3) @(negedge clk);
    chk(core_rst_o == 0, "R9 release", core_rst_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule